// File: doc/BRIEF.md
# Two-Channel Oversampled Input Capture

This block samples a set of digital inputs, by default two, at a fast sampling pulse and packs one bit per channel per pulse into a per-channel bit image. A slower cycle pulse marks the boundary of each acquisition cycle. At that boundary, the bits gathered since the previous boundary become the readable image. The sample taken on the boundary pulse itself becomes sample 0 of the new cycle. Each channel uses two banks that swap roles at every boundary, so a reader sees a frozen image for the whole cycle while the next image is being filled.

The number of samples per cycle (the factor) is sampled at each cycle boundary and clamped to the range 1 to the buffer depth. The image is read one byte at a time through a channel select and a byte address. A shared 16-bit cycle counter advances once per published image. A valid flag stays low through a start-up window of published images. A sticky underrun flag records any cycle that ended before it collected its full factor of samples. Inputs arrive already synchronized, and the block applies no filtering to them.

Top module: `osc_capture`

## Requirements
- R1: Sample k of a cycle is stored at bit (k mod 8) of byte (k div 8) of its channel's image, and each channel stores only its own input bit.
- R2: At each cycle pulse after the first, the samples of the cycle that just ended become readable. The sample taken on the cycle pulse is sample 0 of the new cycle. The readable image does not change until the next cycle pulse.
- R3: Image bits past the last stored sample read as 0, and byte addresses at or above ceil(MAX_SAMPLES/8) read as 0.
- R4: The factor is captured at each cycle pulse and clamped to 1..MAX_SAMPLES, with 0 treated as 1. Samples beyond the factor within a cycle are discarded. With a factor of 1, only bit 0 of byte 0 can be nonzero.
- R5: A channel holds up to MAX_SAMPLES samples, 1000 by default, which occupy 125 bytes per channel.
- R6: The cycle counter is 16 bits wide, reads 0 after reset, increases by exactly 1 at every published image, wraps from 65535 to 0, and is shared by all channels.
- R7: The valid flag is low for the first WARMUP published images (60 by default), becomes high at the next publication, and never falls afterwards.
- R8: A cycle that ends with fewer accepted samples than its factor is still published as a short image, and it sets the underrun flag, which stays set until reset. A cycle that reaches its factor does not set the flag.
- R9: A high pulse lasting a single sample is stored exactly as sampled, with no filtering.
- R10: Sampling pulses before the first cycle pulse are discarded, and the first cycle pulse publishes nothing, so the counter stays 0.
- R11: After reset the counter, the valid flag and the underrun flag are 0, and every image byte reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fast_tick | input | 1 | Sampling pulse, one sample per channel |
| slow_tick | input | 1 | Cycle pulse, publishes and starts a new cycle |
| factor | input | IDX_W (10) | Samples per cycle, captured at the cycle pulse |
| din | input | NUM_CH (2) | Synchronized input bits, one per channel |
| rd_ch | input | CH_W (1) | Channel select for readback |
| rd_addr | input | ADDR_W (7) | Byte address into the readable image |
| rd_data | output | 8 | Selected image byte |
| cycle_cnt | output | CNT_W (16) | Shared published-cycle counter |
| img_valid | output | 1 | High once the start-up window has passed |
| underrun | output | 1 | Sticky flag for a short cycle |

## Verification
The bound checker watches several properties on every clock. The counter moves only by one step and only after a cycle pulse. The valid and underrun flags never fall. The valid flag rises exactly when the counter passes the start-up window. The byte read at an unchanged address stays constant between cycle pulses. Addresses past the image always read zero. The bench scenarios cover what depends on the stored data: bit ordering per channel, factor clamping and discarding of excess samples, short-cycle publication, single-sample pulses, discarding of samples before the first cycle pulse, and the counter wrap after 65536 publications.

// File: rtl/osc_pkg.sv
package osc_pkg;

   // Per-clock command from the sequencer to every channel lane
   typedef struct packed {
      logic swap;   // cycle boundary: flip banks, restart the fill
      logic first;  // a sample coincides with the boundary
      logic wr_en;  // store one sample at the current index
      logic sel;    // bank currently being filled
   } osc_cmd_t;

   function automatic int bytes_for(int bits);
      return (bits + 7) / 8;
   endfunction

endpackage

// File: rtl/osc_ctrl.sv
module osc_ctrl
   import osc_pkg::*;
#(
   parameter int MAX_SAMPLES = 1000,
   parameter int CNT_W       = 16,
   parameter int WARMUP      = 60,
   localparam int IDX_W      = $clog2(MAX_SAMPLES + 1),
   localparam int WARM_W     = $clog2(WARMUP + 2)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fast_tick,
   input  logic             slow_tick,
   input  logic [IDX_W-1:0] factor,
   output osc_cmd_t         cmd,
   output logic [IDX_W-1:0] wr_idx,
   output logic [CNT_W-1:0] cycle_cnt,
   output logic             img_valid,
   output logic             underrun
);

   logic [IDX_W-1:0]  idx_q, n_q, n_eff;
   logic [CNT_W-1:0]  cnt_q;
   logic [WARM_W-1:0] warm_q;
   logic              sel_q, started_q, valid_q, under_q;
   logic              accept;

   always_comb begin
      if (factor == '0)
         n_eff = IDX_W'(1);
      else if (factor > IDX_W'(MAX_SAMPLES))
         n_eff = IDX_W'(MAX_SAMPLES);
      else
         n_eff = factor;
   end

   assign accept = fast_tick && !slow_tick && started_q && (idx_q < n_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q     <= '0;
         n_q       <= IDX_W'(1);
         cnt_q     <= '0;
         warm_q    <= '0;
         sel_q     <= 1'b0;
         started_q <= 1'b0;
         valid_q   <= 1'b0;
         under_q   <= 1'b0;
      end else if (slow_tick) begin
         n_q       <= n_eff;
         idx_q     <= fast_tick ? IDX_W'(1) : '0;
         sel_q     <= ~sel_q;
         started_q <= 1'b1;
         if (started_q) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (idx_q < n_q)
               under_q <= 1'b1;
            if (warm_q == WARM_W'(WARMUP))
               valid_q <= 1'b1;
            else
               warm_q <= warm_q + WARM_W'(1);
         end
      end else if (accept) begin
         idx_q <= idx_q + IDX_W'(1);
      end
   end

   assign cmd.swap  = slow_tick;
   assign cmd.first = fast_tick;
   assign cmd.wr_en = accept;
   assign cmd.sel   = sel_q;
   assign wr_idx    = idx_q;
   assign cycle_cnt = cnt_q;
   assign img_valid = valid_q;
   assign underrun  = under_q;

endmodule

// File: rtl/osc_lane.sv
module osc_lane
   import osc_pkg::*;
#(
   parameter int MAX_SAMPLES = 1000,
   localparam int IDX_W      = $clog2(MAX_SAMPLES + 1),
   localparam int NBYTES     = bytes_for(MAX_SAMPLES),
   localparam int BITS       = NBYTES * 8,
   localparam int ADDR_W     = (NBYTES > 1) ? $clog2(NBYTES) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  osc_cmd_t          cmd,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              din_bit,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_byte
);

   logic [BITS-1:0] bank_q [2];

   // The bank that starts filling is cleared whole, so short images read zero past their end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q[0] <= '0;
         bank_q[1] <= '0;
      end else if (cmd.swap) begin
         bank_q[~cmd.sel] <= BITS'(cmd.first & din_bit);
      end else if (cmd.wr_en) begin
         bank_q[cmd.sel][wr_idx] <= din_bit;
      end
   end

   always_comb begin
      rd_byte = '0;
      if (32'(rd_addr) < NBYTES)
         rd_byte = bank_q[~cmd.sel][32'(rd_addr) * 8 +: 8];
   end

endmodule

// File: rtl/osc_capture.sv
module osc_capture
   import osc_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int MAX_SAMPLES = 1000,
   parameter int CNT_W       = 16,
   parameter int WARMUP      = 60,
   localparam int IDX_W      = $clog2(MAX_SAMPLES + 1),
   localparam int NBYTES     = bytes_for(MAX_SAMPLES),
   localparam int ADDR_W     = (NBYTES > 1) ? $clog2(NBYTES) : 1,
   localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fast_tick,
   input  logic              slow_tick,
   input  logic [IDX_W-1:0]  factor,
   input  logic [NUM_CH-1:0] din,
   input  logic [CH_W-1:0]   rd_ch,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic [CNT_W-1:0]  cycle_cnt,
   output logic              img_valid,
   output logic              underrun
);

   if (NUM_CH < 1)       begin : g_bad_ch   $error("NUM_CH must be at least 1");       end
   if (MAX_SAMPLES < 1)  begin : g_bad_max  $error("MAX_SAMPLES must be at least 1");  end
   if (CNT_W < 2)        begin : g_bad_cnt  $error("CNT_W must be at least 2");        end
   if (WARMUP < 0)       begin : g_bad_warm $error("WARMUP must not be negative");     end

   osc_cmd_t         cmd;
   logic [IDX_W-1:0] wr_idx;
   logic [7:0]       lane_byte [NUM_CH];

   osc_ctrl #(
      .MAX_SAMPLES (MAX_SAMPLES),
      .CNT_W       (CNT_W),
      .WARMUP      (WARMUP)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .fast_tick (fast_tick),
      .slow_tick (slow_tick),
      .factor    (factor),
      .cmd       (cmd),
      .wr_idx    (wr_idx),
      .cycle_cnt (cycle_cnt),
      .img_valid (img_valid),
      .underrun  (underrun)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
      osc_lane #(
         .MAX_SAMPLES (MAX_SAMPLES)
      ) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .cmd     (cmd),
         .wr_idx  (wr_idx),
         .din_bit (din[g]),
         .rd_addr (rd_addr),
         .rd_byte (lane_byte[g])
      );
   end

   // Full power-of-two channel count needs no range guard on the select
   if (NUM_CH == (1 << CH_W)) begin : g_sel_full
      assign rd_data = lane_byte[rd_ch];
   end else begin : g_sel_guard
      always_comb begin
         rd_data = '0;
         for (int c = 0; c < NUM_CH; c++)
            if (32'(rd_ch) == c)
               rd_data = lane_byte[c];
      end
   end

endmodule

// File: rtl/osc_capture_chk.sv
module osc_capture_chk #(
   parameter int CNT_W  = 16,
   parameter int WARMUP = 60,
   parameter int NBYTES = 125,
   parameter int ADDR_W = 7,
   parameter int CH_W   = 1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              slow_tick,
   input logic [CH_W-1:0]   rd_ch,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [7:0]        rd_data,
   input logic [CNT_W-1:0]  cycle_cnt,
   input logic              img_valid,
   input logic              underrun
);

   assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cycle_cnt) |-> cycle_cnt == $past(cycle_cnt) + CNT_W'(1));

   assert_cnt_after_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cycle_cnt) |-> $past(slow_tick));

   assert_valid_never_falls_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(img_valid));

   assert_valid_rise_point_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(img_valid) |-> cycle_cnt == CNT_W'(WARMUP + 1));

   assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(underrun));

   assert_image_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(slow_tick) && $stable(rd_ch) && $stable(rd_addr)) |-> $stable(rd_data));

   assert_tail_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(rd_addr) >= NBYTES) |-> rd_data == 8'h00);

endmodule

bind osc_capture osc_capture_chk #(
   .CNT_W  (CNT_W),
   .WARMUP (WARMUP),
   .NBYTES (NBYTES),
   .ADDR_W (ADDR_W),
   .CH_W   (CH_W)
) u_chk (.*);

// File: tb/sim_osc_capture.sv
module sim_osc_capture;

   localparam int CLK_P = 10;
   localparam int MAXS  = 1000;
   localparam int NB    = 125;
   localparam int WARM  = 60;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fast_tick = 1'b0;
   logic       slow_tick = 1'b0;
   logic [9:0] factor = 10'd8;
   logic [1:0] din = 2'b00;
   logic       rd_ch = 1'b0;
   logic [6:0] rd_addr = 7'd0;
   logic [7:0]  rd_data;
   logic [15:0] cycle_cnt;
   logic        img_valid, underrun;

   always #(CLK_P/2) clk = ~clk;

   osc_capture u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .fast_tick (fast_tick),
      .slow_tick (slow_tick),
      .factor    (factor),
      .din       (din),
      .rd_ch     (rd_ch),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .cycle_cnt (cycle_cnt),
      .img_valid (img_valid),
      .underrun  (underrun)
   );

   int n_chk = 0;
   int n_fail = 0;
   int pubs = 0;
   bit started = 0;
   bit exp_under = 0;
   bit cur_b [2][MAXS];
   bit prv_b [2][MAXS];
   int cur_cnt = 0;
   int cur_neff = 1;

   function automatic bit pat(int ch, int k, int seed);
      if (seed < 0) return (k == -seed);
      return 1'(((k * 37 + seed * 11 + ch * 53) >> 2) & 1);
   endfunction

   function automatic int clampn(int n);
      if (n < 1) return 1;
      if (n > MAXS) return MAXS;
      return n;
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic check_image(string req);
      for (int ch = 0; ch < 2; ch++) begin
         for (int b = 0; b < 128; b++) begin
            logic [7:0] e;
            rd_ch = ch[0];
            rd_addr = b[6:0];
            #1;
            e = '0;
            if (b < NB)
               for (int i = 0; i < 8; i++) e[i] = prv_b[ch][b*8 + i];
            check(req, rd_data, e);
         end
      end
   endtask

   // One acquisition cycle: pulse with sample 0, then nsamp-1 spaced samples
   task automatic do_cycle(int n, int nsamp, int seed, bit chk, string tag);
      int neff = clampn(n);
      @(negedge clk);
      factor = n[9:0];
      slow_tick = 1'b1;
      fast_tick = 1'b1;
      din = {pat(1, 0, seed), pat(0, 0, seed)};
      @(negedge clk);
      slow_tick = 1'b0;
      fast_tick = 1'b0;
      if (started) begin
         pubs++;
         if (cur_cnt < cur_neff) exp_under = 1;
         prv_b = cur_b;
      end
      started = 1;
      cur_b = '{default: 0};
      cur_neff = neff;
      for (int c = 0; c < 2; c++) cur_b[c][0] = pat(c, 0, seed);
      cur_cnt = 1;
      if (chk) begin
         check_image(tag);
         check("R6 counter", cycle_cnt, pubs % 65536);
         check("R7 valid", img_valid, (pubs > WARM) ? 1 : 0);
         check("R8 underrun", underrun, exp_under);
      end
      for (int k = 1; k < nsamp; k++) begin
         @(negedge clk);
         fast_tick = 1'b1;
         din = {pat(1, k, seed), pat(0, k, seed)};
         if (k < neff) begin
            for (int c = 0; c < 2; c++) cur_b[c][k] = pat(c, k, seed);
            cur_cnt++;
         end
         @(negedge clk);
         fast_tick = 1'b0;
      end
      if (chk) begin
         logic [7:0] e;
         rd_ch = 1'b1;
         rd_addr = 7'd0;
         #1;
         for (int i = 0; i < 8; i++) e[i] = prv_b[1][i];
         check("R2 image frozen during fill", rd_data, e);
      end
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 counter", cycle_cnt, 0);
      check("R11 valid", img_valid, 0);
      check("R11 underrun", underrun, 0);
      rd_ch = 1'b1; rd_addr = 7'd3; #1;
      check("R11 image", rd_data, 0);
      rd_ch = 1'b0; rd_addr = 7'd0; #1;
      check("R11 image", rd_data, 0);
   endtask

   task automatic t_prestart();
      repeat (4) begin
         @(negedge clk);
         fast_tick = 1'b1;
         din = 2'b11;
      end
      @(negedge clk);
      fast_tick = 1'b0;
      do_cycle(8, 8, 1, 0, "R10");
      check("R10 first pulse publishes nothing", cycle_cnt, 0);
      do_cycle(16, 16, 2, 1, "R10 R1 R2 image after start");
   endtask

   task automatic t_order();
      do_cycle(13, 13, 3, 1, "R1 R2 16-sample image");
      do_cycle(8, 8, 4, 1, "R1 R3 13-sample image");
   endtask

   task automatic t_factor();
      do_cycle(1, 5, 5, 1, "R1 8-sample image");
      do_cycle(0, 1, 6, 1, "R4 factor 1 image");
      do_cycle(8, 12, 7, 1, "R4 factor 0 image");
      do_cycle(1000, 1000, 8, 1, "R4 excess samples dropped");
   endtask

   task automatic t_depth();
      do_cycle(1023, 1003, 9, 1, "R5 full depth image");
      do_cycle(16, 16, -5, 1, "R4 R5 clamped factor image");
      do_cycle(8, 8, 10, 1, "R9 single pulse image");
   endtask

   task automatic t_warmup();
      while (pubs <= WARM)
         do_cycle(4, 4, 11 + pubs, 1, "R7 warm-up image");
      check("R7 valid after window", img_valid, 1);
   endtask

   task automatic t_short();
      do_cycle(8, 3, 12, 1, "R8 before short cycle");
      do_cycle(8, 8, 13, 1, "R8 short image");
      do_cycle(8, 8, 14, 1, "R8 sticky image");
      check("R8 sticky", underrun, 1);
   endtask

   task automatic t_wrap();
      int hold = 65536 - (pubs % 65536) + 3;
      @(negedge clk);
      factor = 10'd1;
      slow_tick = 1'b1;
      fast_tick = 1'b1;
      din = 2'b00;
      if (cur_cnt < cur_neff) exp_under = 1;
      repeat (hold) @(negedge clk);
      slow_tick = 1'b0;
      fast_tick = 1'b0;
      pubs += hold;
      check("R6 counter wrap", cycle_cnt, 3);
      cur_b = '{default: 0};
      cur_cnt = 1;
      cur_neff = 1;
      do_cycle(8, 8, 15, 1, "R6 image after wrap");
   endtask

   initial begin
      #(CLK_P * 190000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      t_reset();
      t_prestart();
      t_order();
      t_factor();
      t_depth();
      t_warmup();
      t_short();
      t_wrap();
      summary();
      $finish;
   end

endmodule